// File: doc/BRIEF.md
# Byte ALU with Status Flags

A purely combinational arithmetic-logic unit for the execute stage of a small 8-bit microcontroller datapath. Each cycle it receives an operation code, two byte operands, a 6-bit constant and the current status byte. It returns a result byte, a second result byte and the updated status byte. The register file, instruction decode and branch logic sit around it. They select the operands and write back whatever the instruction calls for.

Byte operations cover addition and subtraction, each with or without the incoming carry. There are comparisons, the bitwise logic group, complement, negate, increment and decrement, two right shifts, rotate-through-carry and nibble swap. A word path adds a constant to, or subtracts one from, the 16-bit value `{opnd_b, opnd_a}`, which is a register pair whose index is decoded upstream. Every operation follows precise flag rules. These include borrow and carry chaining for multi-byte arithmetic, and special overflow cases for negate, increment and decrement.

Status byte positions, bit 0 upward: C (carry), Z (zero), N (negative), V (overflow), S (sign), H (half carry), T (transfer bit), I (interrupt enable).

Top module: `byte_alu`

## Requirements
- R1: Operation codes on `alu_op` are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 and, 7 or, 8 xor, 9 complement, 10 negate, 11 increment, 12 decrement, 13 logical shift right, 14 arithmetic shift right, 15 rotate right through carry, 16 nibble swap, 17 word add constant, 18 word subtract constant. Status bits 7 (I) and 6 (T) always leave unchanged.
- R2: Add (code 0) and add with carry (code 1, which also adds status bit 0) give H = carry out of bit 3, C = carry out of bit 7, V = signed overflow, N = result bit 7, Z = result zero, S = N xor V.
- R3: Subtract and compare (codes 2–5, where codes 3 and 5 also subtract status bit 0) set H and C to the borrows out of bits 3 and 7, V to signed overflow, N to bit 7 of the difference and S to N xor V. Codes 2 and 4 set Z when the difference is zero. Codes 3 and 5 set Z only when the difference is zero and Z was already set. For codes 4 and 5, `res_lo` equals `opnd_a`.
- R4: And, or and xor (codes 6–8) clear V, copy result bit 7 to N and S, set Z on a zero result, and keep C and H.
- R5: Complement (code 9) inverts `opnd_a`, applies the R4 flag rules and forces C to 1.
- R6: Negate (code 10) returns 0 minus `opnd_a`. It sets C when the result is nonzero and Z when it is zero. It sets V when the result is 0x80. N is result bit 7, S is N xor V, and H is bit 3 of (result OR operand).
- R7: Increment and decrement (codes 11, 12) set V when the result becomes 0x80 and 0x7F respectively. N is result bit 7, S is N xor V, Z marks a zero result, and C and H are kept.
- R8: Shifts and the rotate (codes 13–15) move the old bit 0 into C. Code 13 shifts 0 into bit 7, code 14 keeps bit 7, and code 15 inserts the old C into bit 7. N is result bit 7, V = N xor C, S = N xor V, Z marks a zero result, and H is kept.
- R9: Nibble swap (code 16) exchanges the two halves of `opnd_a` and leaves the status byte unchanged.
- R10: Word codes 17 and 18 add or subtract the unsigned `imm6` to or from `{opnd_b, opnd_a}`, with the result on `{res_hi, res_lo}`. Z marks a zero word and N is bit 15. For an add, C = bit 15 falling from 1 to 0 and V = bit 15 rising from 0 to 1. For a subtract, C = bit 15 rising and V = bit 15 falling. S = N xor V and H is kept.
- R11: Codes 19 to 31 return `opnd_a` and leave the status byte unchanged.
- R12: For every code other than 17 and 18, `res_hi` equals `opnd_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 5 | Operation code (R1) |
| opnd_a | input | 8 | First operand, low byte of the word path |
| opnd_b | input | 8 | Second operand, high byte of the word path |
| imm6 | input | 6 | Unsigned constant for word operations |
| flags_in | input | 8 | Current status byte |
| res_lo | output | 8 | Result byte, low byte of a word result |
| res_hi | output | 8 | High byte of a word result, otherwise `opnd_b` |
| flags_out | output | 8 | Updated status byte |

## Verification
The unit holds no state, so every output is due in the same cycle as the inputs that produce it, after zero clock edges. The bench drives a new vector just after a falling clock edge. It compares outputs two nanoseconds later, still well before the next rising edge, so each check sees only settled combinational values of the vector just applied. Directed corners such as 0x80 negation, the wrap points of increment and decrement, carry chaining of Z, and word wrap at 0xFFFF come first. A seeded random sweep over all codes, including unused ones, follows.

// File: rtl/byte_alu.sv
module byte_alu (
  input  logic [4:0] alu_op,
  input  logic [7:0] opnd_a,
  input  logic [7:0] opnd_b,
  input  logic [5:0] imm6,
  input  logic [7:0] flags_in,
  output logic [7:0] res_lo,
  output logic [7:0] res_hi,
  output logic [7:0] flags_out
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC = 5'd12, OP_LSR = 5'd13, OP_ASR = 5'd14, OP_ROR = 5'd15;
  localparam logic [4:0] OP_SWP = 5'd16, OP_ADW = 5'd17, OP_SBW = 5'd18;

  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  logic       cin;
  logic [7:0] r, cv;
  logic [7:0] hi;
  logic [7:0] f;
  logic [15:0] wop, wr;
  logic       upd_s;

  assign cin = flags_in[FC] & (alu_op == OP_ADC || alu_op == OP_SBC || alu_op == OP_CPC);
  assign wop = {opnd_b, opnd_a};

  always_comb begin
    r     = opnd_a;
    hi    = opnd_b;
    f     = flags_in;
    cv    = 8'h00;
    wr    = wop;
    upd_s = 1'b1;
    case (alu_op)
      OP_ADD, OP_ADC: begin
        r     = opnd_a + opnd_b + {7'd0, cin};
        cv    = (opnd_a & opnd_b) | (opnd_a & ~r) | (opnd_b & ~r);
        f[FH] = cv[3];
        f[FC] = cv[7];
        f[FV] = (opnd_a[7] & opnd_b[7] & ~r[7]) | (~opnd_a[7] & ~opnd_b[7] & r[7]);
        f[FN] = r[7];
        f[FZ] = (r == 8'h00);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
        r     = opnd_a - opnd_b - {7'd0, cin};
        cv    = (~opnd_a & opnd_b) | (opnd_b & r) | (r & ~opnd_a);
        f[FH] = cv[3];
        f[FC] = cv[7];
        f[FV] = (opnd_a[7] & ~opnd_b[7] & ~r[7]) | (~opnd_a[7] & opnd_b[7] & r[7]);
        f[FN] = r[7];
        if (alu_op == OP_SBC || alu_op == OP_CPC)
          f[FZ] = (r == 8'h00) & flags_in[FZ];
        else
          f[FZ] = (r == 8'h00);
        if (alu_op == OP_CMP || alu_op == OP_CPC)
          r = opnd_a;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        case (alu_op)
          OP_AND:  r = opnd_a & opnd_b;
          OP_OR:   r = opnd_a | opnd_b;
          OP_XOR:  r = opnd_a ^ opnd_b;
          default: r = ~opnd_a;
        endcase
        f[FV] = 1'b0;
        f[FN] = r[7];
        f[FZ] = (r == 8'h00);
        if (alu_op == OP_COM)
          f[FC] = 1'b1;
      end
      OP_NEG: begin
        r     = 8'h00 - opnd_a;
        f[FC] = (r != 8'h00);
        f[FZ] = (r == 8'h00);
        f[FV] = (r == 8'h80);
        f[FN] = r[7];
        f[FH] = r[3] | opnd_a[3];
      end
      OP_INC, OP_DEC: begin
        r     = (alu_op == OP_INC) ? opnd_a + 8'd1 : opnd_a - 8'd1;
        f[FV] = (alu_op == OP_INC) ? (r == 8'h80) : (r == 8'h7f);
        f[FN] = r[7];
        f[FZ] = (r == 8'h00);
      end
      OP_LSR, OP_ASR, OP_ROR: begin
        case (alu_op)
          OP_LSR:  r = {1'b0, opnd_a[7:1]};
          OP_ASR:  r = {opnd_a[7], opnd_a[7:1]};
          default: r = {flags_in[FC], opnd_a[7:1]};
        endcase
        f[FC] = opnd_a[0];
        f[FN] = r[7];
        f[FV] = r[7] ^ opnd_a[0];
        f[FZ] = (r == 8'h00);
      end
      OP_SWP: begin
        r     = {opnd_a[3:0], opnd_a[7:4]};
        upd_s = 1'b0;
      end
      OP_ADW, OP_SBW: begin
        wr = (alu_op == OP_ADW) ? wop + {10'd0, imm6} : wop - {10'd0, imm6};
        r  = wr[7:0];
        hi = wr[15:8];
        f[FZ] = (wr == 16'h0000);
        f[FN] = wr[15];
        if (alu_op == OP_ADW) begin
          f[FC] = wop[15] & ~wr[15];
          f[FV] = ~wop[15] & wr[15];
        end else begin
          f[FC] = ~wop[15] & wr[15];
          f[FV] = wop[15] & ~wr[15];
        end
      end
      default: upd_s = 1'b0;
    endcase
    if (upd_s)
      f[FS] = f[FN] ^ f[FV];
  end

  assign res_lo    = r;
  assign res_hi    = hi;
  assign flags_out = f;

  always_comb begin
    if (alu_op == OP_NEG && res_lo == 8'h80)
      assert_neg_edge_R6: assert (flags_out[FV] && flags_out[FN] && !flags_out[FS] && flags_out[FC]);
    if (alu_op == OP_INC && opnd_a == 8'h7f)
      assert_inc_ovf_R7: assert (flags_out[FV] && res_lo == 8'h80);
    if (alu_op == OP_DEC && opnd_a == 8'h80)
      assert_dec_ovf_R7: assert (flags_out[FV] && res_lo == 8'h7f);
    if (alu_op >= OP_AND && alu_op <= OP_XOR)
      assert_logic_keep_R4: assert (!flags_out[FV] && flags_out[FC] == flags_in[FC] && flags_out[FH] == flags_in[FH]);
    if (alu_op == OP_COM)
      assert_com_carry_R5: assert (flags_out[FC] && res_lo == ~opnd_a);
    if (alu_op == OP_SWP)
      assert_swap_flags_R9: assert (flags_out == flags_in);
    if (alu_op >= OP_LSR && alu_op <= OP_ROR)
      assert_shift_carry_R8: assert (flags_out[FC] == opnd_a[0]);
    if (alu_op == OP_CMP || alu_op == OP_CPC)
      assert_cmp_keep_R3: assert (res_lo == opnd_a);
  end
endmodule

// File: tb/byte_alu_tb.sv
module byte_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] alu_op;
  logic [7:0] opnd_a, opnd_b, flags_in;
  logic [5:0] imm6;
  logic [7:0] res_lo, res_hi, flags_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  byte_alu dut_i (
    .alu_op(alu_op), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm6(imm6),
    .flags_in(flags_in), .res_lo(res_lo), .res_hi(res_hi), .flags_out(flags_out)
  );

  function automatic logic [23:0] model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                                        input logic [5:0] k, input logic [7:0] fi);
    int ai, bi, ci, ri, sa, sb, sr;
    logic [7:0] r, h, fo;
    logic c, z, n, v, hh;
    int w, wn;
    ai = a; bi = b;
    sa = a[7] ? ai - 256 : ai;
    sb = b[7] ? bi - 256 : bi;
    r = a; h = b; fo = fi;
    c = fi[0]; z = fi[1]; n = fi[2]; v = fi[3]; hh = fi[5];
    ci = (op == 1 || op == 3 || op == 5) ? int'(fi[0]) : 0;
    case (op)
      0, 1: begin
        ri = ai + bi + ci; r = ri[7:0];
        c = ri > 255; hh = ((ai % 16) + (bi % 16) + ci) > 15;
        sr = sa + sb + ci; v = (sr > 127) || (sr < -128);
        n = r[7]; z = r == 0;
      end
      2, 3, 4, 5: begin
        ri = ai - bi - ci; r = ri[7:0];
        c = ri < 0; hh = ((ai % 16) - (bi % 16) - ci) < 0;
        sr = sa - sb - ci; v = (sr > 127) || (sr < -128);
        n = r[7];
        z = (op == 3 || op == 5) ? (r == 0 && fi[1]) : (r == 0);
        if (op >= 4) r = a;
      end
      6, 7, 8, 9: begin
        r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (op == 8) ? (a ^ b) : (8'hff - a);
        v = 0; n = r[7]; z = r == 0;
        if (op == 9) c = 1;
      end
      10: begin
        ri = 256 - ai; r = ri[7:0];
        c = r != 0; z = r == 0; v = r == 8'h80; n = r[7]; hh = r[3] | a[3];
      end
      11, 12: begin
        ri = (op == 11) ? ai + 1 : ai + 255; r = ri[7:0];
        v = (op == 11) ? (a == 8'h7f) : (a == 8'h80); n = r[7]; z = r == 0;
      end
      13, 14, 15: begin
        ri = ai / 2 + ((op == 14 && a[7]) || (op == 15 && fi[0]) ? 128 : 0);
        r = ri[7:0]; c = a[0]; n = r[7]; v = n ^ c; z = r == 0;
      end
      16: r = {a[3:0], a[7:4]};
      17, 18: begin
        w  = bi * 256 + ai;
        wn = (op == 17) ? w + int'(k) : w - int'(k);
        if (op == 17) begin c = wn > 65535; v = (w < 32768) && ((wn % 65536) >= 32768); end
        else begin c = wn < 0; v = (w >= 32768) && (wn < 32768); end
        wn = (wn + 65536) % 65536;
        r = wn[7:0]; h = wn[15:8]; z = wn == 0; n = wn >= 32768;
      end
      default: ;
    endcase
    if (op <= 18 && op != 16) begin
      fo[0] = c; fo[1] = z; fo[2] = n; fo[3] = v; fo[5] = hh; fo[4] = n ^ v;
    end
    return {h, r, fo};
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      0, 1: return "R2";
      2, 3, 4, 5: return "R3";
      6, 7, 8: return "R4";
      9: return "R5";
      10: return "R6";
      11, 12: return "R7";
      13, 14, 15: return "R8";
      16: return "R9";
      17, 18: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [5:0] k, input logic [7:0] fi, input string tag);
    logic [23:0] exp;
    @(negedge clk);
    alu_op = op; opnd_a = a; opnd_b = b; imm6 = k; flags_in = fi;
    #2;
    exp = model(op, a, b, k, fi);
    compared++;
    if ({res_hi, res_lo, flags_out} !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%h b=%h k=%h f=%h: got hi=%h lo=%h fl=%h expected hi=%h lo=%h fl=%h",
               tag, op, a, b, k, fi, res_hi, res_lo, flags_out, exp[23:16], exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    alu_op = 0; opnd_a = 0; opnd_b = 0; imm6 = 0; flags_in = 0;
    repeat (3) @(posedge clk);
    apply(5'd0, 8'h00, 8'h00, 6'd0, 8'h00, "R2");   // reset-state vector: zero add sets Z
    rst_n = 1'b1;
    apply(5'd0, 8'h0f, 8'h01, 6'd0, 8'h00, "R2");   // half carry
    apply(5'd0, 8'h7f, 8'h01, 6'd0, 8'h00, "R2");   // signed overflow
    apply(5'd1, 8'hff, 8'h00, 6'd0, 8'hc1, "R2");   // carry in wraps, I and T kept (R1)
    apply(5'd2, 8'h10, 8'h01, 6'd0, 8'h00, "R3");   // half borrow
    apply(5'd3, 8'h01, 8'h00, 6'd0, 8'h03, "R3");   // chained Z stays
    apply(5'd3, 8'h01, 8'h00, 6'd0, 8'h01, "R3");   // chained Z not set without prior Z
    apply(5'd5, 8'h00, 8'h00, 6'd0, 8'h01, "R3");   // compare with carry borrows, result = a
    apply(5'd4, 8'h80, 8'h01, 6'd0, 8'h00, "R3");   // compare overflow
    apply(5'd6, 8'hf0, 8'h0f, 6'd0, 8'h29, "R4");   // zero result, C and H kept
    apply(5'd9, 8'hff, 8'h00, 6'd0, 8'h00, "R5");
    apply(5'd10, 8'h80, 8'h00, 6'd0, 8'h00, "R6");
    apply(5'd10, 8'h00, 8'h00, 6'd0, 8'h01, "R6");
    apply(5'd11, 8'h7f, 8'h00, 6'd0, 8'h21, "R7");
    apply(5'd12, 8'h80, 8'h00, 6'd0, 8'h00, "R7");
    apply(5'd15, 8'h01, 8'h00, 6'd0, 8'h01, "R8");
    apply(5'd14, 8'h81, 8'h00, 6'd0, 8'h00, "R8");
    apply(5'd13, 8'h01, 8'h00, 6'd0, 8'h20, "R8");
    apply(5'd16, 8'h3c, 8'h55, 6'd0, 8'hff, "R9");
    apply(5'd17, 8'hff, 8'hff, 6'd1, 8'h00, "R10");
    apply(5'd17, 8'hff, 8'h7f, 6'd1, 8'h00, "R10");
    apply(5'd18, 8'h00, 8'h00, 6'd1, 8'h00, "R10");
    apply(5'd18, 8'h00, 8'h80, 6'd63, 8'h00, "R10");
    apply(5'd25, 8'h5a, 8'ha5, 6'd7, 8'h3c, "R11");
    apply(5'd8, 8'h12, 8'h9e, 6'd9, 8'h00, "R12");
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      apply(op, 8'($urandom), 8'($urandom), 6'($urandom), 8'($urandom), tag_of(op));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule